// File: doc/BRIEF.md
# Sampling Window Center Finder

This block picks a sampling delay tap from a calibration sweep. It receives a pass/fail map with one bit per delay tap, where a set bit means that tap sampled correctly. It looks for the longest run of consecutive passing taps and reports where that run starts, how long it is, and one tap inside it to use as the final setting. When no tap passed, it raises an error and reports the failure code 0xFF as the tap.

A one-cycle start strobe captures the map and begins a scan. The scan spends one clock cycle on each candidate start position. From each position it measures the run of passing taps, then jumps past that run. The scan can stop early once a long enough window has been found near the low end of the delay range. When the scan ends, the results are registered, a one-cycle done pulse is raised, and the results stay on the outputs until the next scan finishes. The map is produced elsewhere, and the chosen tap is programmed into a delay line elsewhere.

Top module: `win_center_finder`

## Requirements
- R1: A start strobe seen while idle captures the map and begins a scan. A start strobe seen while a scan is running is ignored: the result reflects the first map only, and only one done pulse follows.
- R2: The run length measured from position p counts consecutive set bits upward from bit p. It stops at the first clear bit or after tap NTAPS-1 (tap 31 by default). The reported length is the length of the best run.
- R3: The next scan position is the current position plus the length just measured, or plus 1 when that length is zero. The best run is replaced only by a strictly longer run, so among equal-length runs the lowest-indexed one is reported.
- R4: The scan ends early, right after a measurement, when the measured length is at least 8 and the best run's start is below 4.
- R5: When the best run starts at tap 0, the final tap is start + len/3. Otherwise it is start + len/2. Both use integer division and are taken modulo NTAPS.
- R6: An all-zero map produces error = 1, final tap 0xFF, start 0 and length 0. Every other map produces error = 0.
- R7: The done output is high for exactly one cycle per completed scan. At that moment start, length, tap and error are valid, and they hold their values until the next scan completes.
- R8: After reset, done and error are 0 and start, length and tap are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to scan the map |
| map_i | input | 32 | Pass/fail map, bit i set when tap i passed |
| start_o | output | 8 | First tap of the best run |
| maxlen_o | output | 8 | Length of the best run |
| phase_o | output | 8 | Chosen tap, or 0xFF on error |
| err_o | output | 1 | No passing tap in the map |
| done_o | output | 1 | One-cycle pulse when results are updated |

## Verification
The bench builds the block with its default parameters: 32 taps, an early-stop length of 8 and an early-stop start bound of 4. With 32 taps, the bench can place runs at tap 0, at tap 31 and across the whole map, so the one-third rule, the one-half rule and the full-length run can each be reached. The early-stop values of 8 and 4 let maps with a start of 3 versus 4, and a run of 8 versus a later longer run, separate the early-exit results from the full-scan results.

// File: rtl/wcf_pkg.sv
package wcf_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} wcf_state_e;
    localparam logic [7:0] PHASE_FAIL = 8'hFF;
endpackage

// File: rtl/wcf_run_len.sv
// Length of the run of set bits starting at position pos_i.
module wcf_run_len #(
    parameter int NTAPS = 32,
    localparam int CNT_W = $clog2(NTAPS + 1)
) (
    input  logic [NTAPS-1:0] map_i,
    input  logic [CNT_W-1:0] pos_i,
    output logic [CNT_W-1:0] len_o
);
    logic [NTAPS-1:0] shifted;
    logic             stop;

    always_comb begin
        shifted = map_i >> pos_i;
        len_o   = '0;
        stop    = 1'b0;
        for (int i = 0; i < NTAPS; i++) begin
            if (!stop && shifted[i]) begin
                len_o = len_o + 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wcf_phase_pick.sv
// Chooses the tap inside the best window.
module wcf_phase_pick #(
    parameter int NTAPS = 32,
    localparam int CNT_W = $clog2(NTAPS + 1),
    localparam int IDX_W = $clog2(NTAPS)
) (
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic [IDX_W-1:0] phase_o
);
    logic [CNT_W:0] sum;

    always_comb begin
        if (start_i == '0) begin
            sum = {1'b0, start_i} + {1'b0, len_i / 3};
        end else begin
            sum = {1'b0, start_i} + {1'b0, len_i >> 1};
        end
        phase_o = sum[IDX_W-1:0];
    end
endmodule

// File: rtl/win_center_finder.sv
module win_center_finder #(
    parameter int NTAPS       = 32,
    parameter int EARLY_LEN   = 8,
    parameter int EARLY_START = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [31:0]      map_i,
    output logic [7:0]       start_o,
    output logic [7:0]       maxlen_o,
    output logic [7:0]       phase_o,
    output logic             err_o,
    output logic             done_o
);
    import wcf_pkg::*;

    localparam int CNT_W = $clog2(NTAPS + 1);
    localparam int IDX_W = $clog2(NTAPS);

    typedef struct packed {
        wcf_state_e       state;
        logic [NTAPS-1:0] map;
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] best_start;
        logic [CNT_W-1:0] best_len;
        logic [7:0]       res_start;
        logic [7:0]       res_len;
        logic [7:0]       res_phase;
        logic             res_err;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;

    logic [CNT_W-1:0] run_len;
    logic [CNT_W-1:0] cand_start;
    logic [CNT_W-1:0] cand_len;
    logic [IDX_W-1:0] cand_phase;
    logic [CNT_W:0]   next_pos;
    logic             finish;

    wcf_run_len #(.NTAPS(NTAPS)) u_run (
        .map_i (r_q.map),
        .pos_i (r_q.pos),
        .len_o (run_len)
    );

    wcf_phase_pick #(.NTAPS(NTAPS)) u_pick (
        .start_i (cand_start),
        .len_i   (cand_len),
        .phase_o (cand_phase)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        cand_start = r_q.best_start;
        cand_len   = r_q.best_len;
        if (run_len > r_q.best_len) begin
            cand_start = r_q.pos;
            cand_len   = run_len;
        end
        next_pos = {1'b0, r_q.pos} + ((run_len == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, run_len});
        finish   = (next_pos >= NTAPS) ||
                   ((run_len >= EARLY_LEN) && (cand_start < EARLY_START));

        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state      = ST_SCAN;
                    r_d.map        = map_i[NTAPS-1:0];
                    r_d.pos        = '0;
                    r_d.best_start = '0;
                    r_d.best_len   = '0;
                end
            end
            default: begin
                r_d.best_start = cand_start;
                r_d.best_len   = cand_len;
                r_d.pos        = next_pos[CNT_W-1:0];
                if (finish) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    if (cand_len == '0) begin
                        r_d.res_err   = 1'b1;
                        r_d.res_start = '0;
                        r_d.res_len   = '0;
                        r_d.res_phase = PHASE_FAIL;
                    end else begin
                        r_d.res_err   = 1'b0;
                        r_d.res_start = 8'(cand_start);
                        r_d.res_len   = 8'(cand_len);
                        r_d.res_phase = 8'(cand_phase);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_o  = r_q.res_start;
    assign maxlen_o = r_q.res_len;
    assign phase_o  = r_q.res_phase;
    assign err_o    = r_q.res_err;
    assign done_o   = r_q.done;

    // R1: a strobe during a scan leaves the captured map alone
    assert_ignore_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SCAN && start_i) |=> $stable(r_q.map));

    // R2: a nonzero run can only begin on a passing tap
    assert_run_on_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SCAN && run_len != '0) |-> r_q.map[r_q.pos[IDX_W-1:0]]);

    // R3: the best length never shrinks during a scan
    assert_best_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SCAN && $past(r_q.state) == ST_SCAN) |->
        (r_q.best_len >= $past(r_q.best_len)));

    // R5: the chosen tap lies inside the reported window
    assert_phase_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ((phase_o >= start_o) &&
                                ({1'b0, phase_o} < ({1'b0, start_o} + {1'b0, maxlen_o}))));

    // R6: the error result carries the failure code and empty window
    assert_err_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (phase_o == PHASE_FAIL && maxlen_o == 8'd0 && start_o == 8'd0));

    // R7: done never lasts two cycles
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: results hold between completions
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(phase_o));
endmodule

// File: tb/tb_win_center_finder.sv
module tb_win_center_finder;
    typedef struct {
        logic [7:0] st;
        logic [7:0] ln;
        logic [7:0] ph;
        logic       er;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] map_i = '0;
    logic [7:0]  start_o, maxlen_o, phase_o;
    logic        err_o, done_o;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];
    logic prev_done = 1'b0;

    always #5 clk = ~clk;

    win_center_finder dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .map_i(map_i),
        .start_o(start_o), .maxlen_o(maxlen_o), .phase_o(phase_o),
        .err_o(err_o), .done_o(done_o)
    );

    function automatic exp_t model(input logic [31:0] m, input string tag);
        exp_t e;
        int s = 0, bs = 0, bl = 0, l;
        e.tag = tag;
        if (m == 0) begin
            e.st = 0; e.ln = 0; e.ph = 8'hFF; e.er = 1'b1;
            return e;
        end
        while (s < 32) begin
            l = 0;
            while (s + l < 32 && m[s + l]) l++;
            if (l > bl) begin bs = s; bl = l; end
            s += (l != 0) ? l : 1;
            if (l >= 8 && bs < 4) break;
        end
        e.st = 8'(bs); e.ln = 8'(bl); e.er = 1'b0;
        e.ph = (bs == 0) ? 8'((bs + bl / 3) % 32) : 8'((bs + bl / 2) % 32);
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare on every done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done) check(1'b0, "R7 done width", 2, 1);
            if (done_o) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(start_o == e.st, {e.tag, " R3 start"}, start_o, e.st);
                    check(maxlen_o == e.ln, {e.tag, " R2 maxlen"}, maxlen_o, e.ln);
                    check(phase_o == e.ph, {e.tag, " R5 phase"}, phase_o, e.ph);
                    check(err_o == e.er, {e.tag, " R6 err"}, err_o, e.er);
                end
            end
            prev_done = done_o;
        end
    end

    task automatic run(input logic [31:0] m, input string tag);
        @(negedge clk);
        start_i = 1'b1; map_i = m;
        q.push_back(model(m, tag));
        @(negedge clk);
        start_i = 1'b0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [7:0]  hp;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(done_o == 0 && err_o == 0, "R8 flags", {done_o, err_o}, 0);
        check(start_o == 0 && maxlen_o == 0 && phase_o == 0, "R8 data",
              {start_o, maxlen_o, phase_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(32'h0000_0000, "R6");
        run(32'hFFFF_FFFF, "R5 full");
        run(32'h0000_0020, "R2 single");
        run(32'h8000_0000, "R2 top");
        run(32'h0000_1C07, "R3 tie");
        run(32'hFFF0_03FF, "R4 stop");
        run(32'hFFFF_87F8, "R4 start3");
        run(32'hFFFF_8FF0, "R4 start4");
        run(32'h0F0F_F0F0, "R3 mixed");
        // explicit values for the early-stop cases
        run(32'hFFF0_03FF, "R4 exp");
        check(start_o == 0 && maxlen_o == 10 && phase_o == 3, "R4 early", phase_o, 3);
        run(32'hFFFF_8FF0, "R4 exp2");
        check(start_o == 15 && maxlen_o == 17 && phase_o == 23, "R4 full scan", phase_o, 23);

        // R7 hold after done
        hp = phase_o;
        repeat (10) @(negedge clk);
        check(phase_o == hp && maxlen_o == 17, "R7 hold", phase_o, hp);

        // R1 strobe while busy is ignored
        @(negedge clk);
        start_i = 1'b1; map_i = 32'h0000_0F00;
        q.push_back(model(32'h0000_0F00, "R1 first"));
        @(negedge clk);
        map_i = 32'hFFFF_FFFF;
        @(negedge clk);
        start_i = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        check(phase_o == 8'd10, "R1 second ignored", phase_o, 10);

        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 20; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run(lfsr | (lfsr << 1) | (lfsr >> 2), "R3 rand");
        end

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule